// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a binary up-counter, four bits wide by default, whose bits all change together on the rising clock edge. An active-low clear empties it at once, without waiting for the clock. An active-low load copies a parallel data word in on the next edge. Two count enables must both be high for the counter to advance.

The second enable, `chain_en`, also gates a carry output. That output is high only while the count is all ones. Several instances form a wider synchronous counter with no extra gating: all stages share the clock, and each stage's `carry_out` drives the next stage's `chain_en`.

Each edge takes one of four operations, in strict priority: CLEAR (asynchronous, `clear_n` low), LOAD (`load_n` low), COUNT (both enables high), HOLD (otherwise). The transitions out of the current value are CLEAR to zero, LOAD to `data_in`, COUNT to value plus one with wrap from all ones to zero, and HOLD to the same value.

Top module: `cascade_counter`

## Requirements
- R1: While `clear_n` is low, `count` is 0000 and `carry_out` is low. This takes effect as soon as `clear_n` falls, also between clock edges, whatever the other inputs are.
- R2: Clear outranks load: a rising edge while `clear_n` and `load_n` are both low leaves `count` at 0000.
- R3: With `clear_n` high and `load_n` low, a rising edge sets `count` to `data_in`, for any levels of `count_en` and `chain_en`.
- R4: With `clear_n` and `load_n` high and both enables high, a rising edge raises `count` by one, all bits updating on that edge.
- R5: With `clear_n` and `load_n` high and either enable low, `count` keeps its value across rising edges.
- R6: `carry_out` is high exactly when `chain_en` is high and `count` is 1111. It follows these inputs combinationally.
- R7: Counting from 1111 gives 0000 on the next edge.
- R8: Only the enable levels present at the rising edge matter; pulses on `count_en` or `chain_en` between edges have no effect on `count`.
- R9: Two stages, the upper one's `chain_en` fed by the lower one's `carry_out`, form an 8-bit counter. The upper nibble advances exactly once per 16 lower counts and never while the lower stage's `chain_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| count_en | input | 1 | Count enable (does not gate the carry) |
| chain_en | input | 1 | Count enable that also gates `carry_out` |
| data_in | input | WIDTH | Parallel load value |
| count | output | WIDTH | Current count |
| carry_out | output | 1 | Look-ahead carry to the next stage |

## Verification
Every one of the sixteen values is loaded under all four enable combinations. This separates a load that really ignores the enables from one that is gated by them. Every value is also held under each of the three non-counting enable pairs, and the carry is checked at each point, which separates the two enables' roles. A full count sweep through the wrap, a clear dropped in the middle of a clock phase while load is active, and enable pulses placed between edges pin down the priority order and edge-only sampling. A 300-step run of two chained stages, with the lower stage's chain enable then held low at 1111, shows that the upper nibble advances once per sixteen counts and only through the carry.

// File: rtl/cnt_pkg.sv
`timescale 1ns/1ps
package cnt_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2
    } cnt_op_e;
endpackage

// File: rtl/cnt_op_decode.sv
`timescale 1ns/1ps
module cnt_op_decode
    import cnt_pkg::*;
(
    input  logic    load_n,
    input  logic    count_en,
    input  logic    chain_en,
    output cnt_op_e op
);
    // Load outranks count; count needs both enables.
    always_comb begin
        unique case ({load_n, count_en & chain_en})
            2'b00, 2'b01: op = OP_LOAD;
            2'b11:        op = OP_COUNT;
            default:      op = OP_HOLD;
        endcase
    end
endmodule

// File: rtl/cnt_lookahead.sv
`timescale 1ns/1ps
module cnt_lookahead #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             chain_en,
    output logic [WIDTH-1:0] incr,
    output logic             carry_out
);
    // ones_below[i] is high when all bits below i are set.
    logic [WIDTH:0] ones_below;
    assign ones_below[0] = 1'b1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign ones_below[i+1] = ones_below[i] & cur[i];
        assign incr[i]         = cur[i] ^ ones_below[i];
    end

    assign carry_out = chain_en & ones_below[WIDTH];
endmodule

// File: rtl/cnt_state_reg.sv
`timescale 1ns/1ps
module cnt_state_reg
    import cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clear_n,
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] data_in,
    input  logic [WIDTH-1:0] incr,
    output logic [WIDTH-1:0] cnt_q
);
    logic [WIDTH-1:0] cnt_d;

    // Next-value selection
    always_comb begin
        unique case (op)
            OP_LOAD:  cnt_d = data_in;
            OP_COUNT: cnt_d = incr;
            OP_HOLD:  cnt_d = cnt_q;
            default:  cnt_d = cnt_q;
        endcase
    end

    // State register with asynchronous clear
    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) cnt_q <= '0;
        else          cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cascade_counter.sv
`timescale 1ns/1ps
module cascade_counter
    import cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clear_n,
    input  logic             load_n,
    input  logic             count_en,
    input  logic             chain_en,
    input  logic [WIDTH-1:0] data_in,
    output logic [WIDTH-1:0] count,
    output logic             carry_out
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    cnt_op_e          op;
    logic [WIDTH-1:0] incr;

    cnt_op_decode u_dec (
        .load_n   (load_n),
        .count_en (count_en),
        .chain_en (chain_en),
        .op       (op)
    );

    cnt_lookahead #(.WIDTH(WIDTH)) u_la (
        .cur       (count),
        .chain_en  (chain_en),
        .incr      (incr),
        .carry_out (carry_out)
    );

    cnt_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk     (clk),
        .clear_n (clear_n),
        .op      (op),
        .data_in (data_in),
        .incr    (incr),
        .cnt_q   (count)
    );

    assert_load_R3: assert property (@(posedge clk) disable iff (!clear_n)
        !load_n |=> (count == $past(data_in)));

    assert_count_R4: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && count_en && chain_en) |=> (count == $past(count) + ONE));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && !(count_en && chain_en)) |=> $stable(count));

    assert_wrap_R7: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && count_en && carry_out) |=> (count == '0));
endmodule

// File: tb/cascade_counter_test.sv
`timescale 1ns/1ps
module cascade_counter_test;
    logic       clk = 1'b0;
    logic       clear_n;
    logic       load_n;
    logic       lo_cnt_en, lo_chain_en;
    logic [3:0] lo_din, hi_din;
    logic [3:0] lo_q, hi_q;
    logic       lo_carry, hi_carry;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    cascade_counter #(.WIDTH(4)) uut (
        .clk(clk), .clear_n(clear_n), .load_n(load_n),
        .count_en(lo_cnt_en), .chain_en(lo_chain_en),
        .data_in(lo_din), .count(lo_q), .carry_out(lo_carry)
    );

    cascade_counter #(.WIDTH(4)) uut_hi (
        .clk(clk), .clear_n(clear_n), .load_n(load_n),
        .count_en(1'b1), .chain_en(lo_carry),
        .data_in(hi_din), .count(hi_q), .carry_out(hi_carry)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load_both(input logic [3:0] lo, input logic [3:0] hi);
        load_n = 1'b0; lo_din = lo; hi_din = hi;
        tick();
        load_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        clear_n = 1'b0; load_n = 1'b1; lo_cnt_en = 1'b1; lo_chain_en = 1'b1;
        lo_din = 4'hA; hi_din = 4'h5;
        tick(); tick();
        // R1: reset state
        check(lo_q == 4'd0, "R1 clear state", lo_q, 0);
        check(lo_carry == 1'b0, "R1 carry in clear", lo_carry, 0);
        clear_n = 1'b1;
        tick();

        // R3: load under every enable combination, all values
        for (int v = 0; v < 16; v++) begin
            for (int e = 0; e < 4; e++) begin
                lo_cnt_en = e[0]; lo_chain_en = e[1];
                load_both(4'(v), 4'(15 - v));
                lo_cnt_en = 1'b0;
                check(lo_q == 4'(v), "R3 load ignores enables", lo_q, v);
            end
        end

        // R5/R6: hold under each non-counting pair, carry follows
        for (int v = 0; v < 16; v++) begin
            for (int e = 0; e < 3; e++) begin
                lo_cnt_en = 1'b0; lo_chain_en = 1'b0;
                load_both(4'(v), 4'h0);
                lo_cnt_en = e[0]; lo_chain_en = e[1];
                tick(); tick();
                check(lo_q == 4'(v), "R5 hold", lo_q, v);
                check(lo_carry == (e[1] && v == 15), "R6 carry", lo_carry,
                      int'(e[1] && v == 15));
            end
        end

        // R4/R6/R7: full count sweep through wrap
        lo_cnt_en = 1'b0; lo_chain_en = 1'b0;
        load_both(4'h0, 4'h0);
        lo_cnt_en = 1'b1; lo_chain_en = 1'b1;
        for (int k = 1; k <= 17; k++) begin
            tick();
            check(lo_q == 4'(k % 16), (k == 16) ? "R7 wrap" : "R4 count", lo_q, k % 16);
            check(lo_carry == ((k % 16) == 15), "R6 carry at ones", lo_carry,
                  int'((k % 16) == 15));
        end

        // R8: enable pulses between edges do nothing
        lo_cnt_en = 1'b0; lo_chain_en = 1'b1;
        load_both(4'h5, 4'h0);
        #1 lo_cnt_en = 1'b1;
        #1 lo_cnt_en = 1'b0;
        tick();
        check(lo_q == 4'h5, "R8 count_en pulse", lo_q, 5);
        lo_cnt_en = 1'b1; lo_chain_en = 1'b0;
        #1 lo_chain_en = 1'b1;
        #1 lo_chain_en = 1'b0;
        tick();
        check(lo_q == 4'h5, "R8 chain_en pulse", lo_q, 5);

        // R1/R2: clear mid-cycle with load active, then an edge
        lo_cnt_en = 1'b1; lo_chain_en = 1'b1;
        load_both(4'h9, 4'h3);
        load_n = 1'b0; lo_din = 4'hC;
        #1 clear_n = 1'b0;
        #0.5;
        check(lo_q == 4'd0, "R1 immediate clear", lo_q, 0);
        check(hi_q == 4'd0, "R1 immediate clear hi", hi_q, 0);
        tick();
        check(lo_q == 4'd0, "R2 clear over load", lo_q, 0);
        clear_n = 1'b1; load_n = 1'b1;
        tick();

        // R9: two-stage cascade
        clear_n = 1'b0; tick(); clear_n = 1'b1;
        lo_cnt_en = 1'b1; lo_chain_en = 1'b1;
        for (int k = 1; k <= 300; k++) begin
            tick();
            check({hi_q, lo_q} == 8'(k % 256), "R9 cascade", {hi_q, lo_q}, k % 256);
        end
        lo_chain_en = 1'b0;
        load_both(4'hF, 4'h3);
        for (int k = 0; k < 5; k++) begin
            tick();
            check(hi_q == 4'h3, "R9 upper holds", hi_q, 3);
            check(lo_q == 4'hF, "R9 lower holds", lo_q, 15);
        end
        lo_chain_en = 1'b1;
        tick();
        check({hi_q, lo_q} == 8'h40, "R9 carry step", {hi_q, lo_q}, 8'h40);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule